// File: doc/BRIEF.md
# Frequency-to-Digital Loop Controller

This block is the digital half of a charge-pump frequency-to-digital converter. A slow square wave from the sensor oscillator front end enters asynchronously. It is synchronised, and each of its rising edges opens a phase window: the positive charge-pump enable turns on and stays on until the next carry of a small reloadable down-counter. That counter advances on a 200 kHz master strobe. Each carry also fires a negative charge-pump pulse of fixed length, 8.5 master periods. The length is timed in 17 half-periods of a 400 kHz strobe.

At every carry, the block reads a five-level quantiser code from an external comparator ADC. The code is synchronised, and the block adds it into a saturating accumulator that forms the second integrator of the loop. The new accumulator value plus a fixed offset becomes the counter's reload value, so it sets the time to the next carry. The loop therefore acts as a second-order noise-shaping modulator. The accumulator value is the frequency word, and it comes with a one-cycle valid strobe per carry. With the default offset, a word of 0 gives a 20-tick carry interval (100 µs), which matches a 10 kHz input.

The phase detector has two states. PD_IDLE moves to PD_CHARGE on a synchronised input rise, and PD_CHARGE moves back to PD_IDLE on a carry. The negative-pulse timer also has two states. NP_IDLE moves to NP_ACTIVE on a carry, NP_ACTIVE reloads itself on a further carry, and NP_ACTIVE returns to NP_IDLE after its final half-tick.

Top module: `fdc_loop_ctrl`

## Requirements
- R1: A synchronous reset (rst high) drives pos_pump_en, neg_pump_en and freq_valid low and freq_word to 0, and leaves the counter at 0, so that the first carry after release falls on the first master tick.
- R2: When meas_in goes high while pos_pump_en is low, pos_pump_en goes high on the third rising clk edge. That is two synchroniser flops plus the state register.
- R3: pos_pump_en falls on the clock edge of a carry. An input rise that arrives while pos_pump_en is high is ignored and is not remembered after the flag clears.
- R4: neg_pump_en rises on the clock edge of a carry and stays high for exactly 17 tick_half strobes (85 clk cycles at the default strobe spacing).
- R5: A carry that arrives while neg_pump_en is high restarts the 17-strobe window, so neg_pump_en stays high without a gap.
- R6: adc_code is decoded as two's complement: 3'b110 = -2, 3'b111 = -1, 3'b000 = 0, 3'b001 = +1, 3'b010 = +2. The unused codes are clamped: 3'b011 counts as +2, and 3'b100 and 3'b101 count as -2.
- R7: On each carry, freq_word becomes the saturated sum of its previous value and the decoded level. The limits are -16 and +12.
- R8: The interval between two carries is (20 + W) master ticks, where W is the freq_word value written at the first of the two carries.
- R9: freq_valid is a single-cycle pulse on the clock edge of each carry. freq_word changes only on that edge.
- R10: With adc_code held at 0 and freq_word at 0, the carry interval is 20 master ticks and freq_word stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_mclk | input | 1 | One-cycle strobe at the 200 kHz master rate |
| tick_half | input | 1 | One-cycle strobe at 400 kHz; every second strobe coincides with tick_mclk |
| meas_in | input | 1 | Asynchronous measured square wave |
| adc_code | input | 3 | Asynchronous quantiser code, two's complement |
| pos_pump_en | output | 1 | Positive charge-pump current enable |
| neg_pump_en | output | 1 | Negative charge-pump current enable |
| freq_word | output | 6 | Filtered frequency word, two's complement |
| freq_valid | output | 1 | One-cycle strobe when freq_word updates |

## Verification
A wrong accumulator value does not stay hidden. It appears in freq_word at the next valid strobe, and it also stretches or shortens the following carry interval by one master tick per unit of error, so the bench measures both the word and the interval at every carry. A stuck phase-detector state shows at pos_pump_en within three clock cycles of an input rise, or at the first carry. A miscounted pulse timer changes the neg_pump_en width by a multiple of five clocks, and a missed restart opens a low gap once intervals are shorter than the pulse.

// File: rtl/fdc_loop_pkg.sv
package fdc_loop_pkg;

    typedef enum logic {
        PD_IDLE   = 1'b0,
        PD_CHARGE = 1'b1
    } pd_state_e;

    typedef enum logic {
        NP_IDLE   = 1'b0,
        NP_ACTIVE = 1'b1
    } np_state_e;

    // Quantiser code to signed level; unused codes clamp to the nearest end.
    function automatic logic signed [2:0] level_of(input logic [2:0] raw);
        logic signed [2:0] lvl;
        unique case (raw)
            3'b000:          lvl = 3'sb000;
            3'b001:          lvl = 3'sb001;
            3'b010, 3'b011:  lvl = 3'sb010;
            3'b111:          lvl = 3'sb111;
            default:         lvl = 3'sb110;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/fdc_sync.sv
module fdc_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/fdc_phase_det.sv
module fdc_phase_det
    import fdc_loop_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic meas_s,
    input  logic carry,
    output logic pos_en
);
    pd_state_e st, st_nx;
    logic      meas_d;
    logic      rise;

    always_ff @(posedge clk) begin
        if (rst) meas_d <= 1'b0;
        else     meas_d <= meas_s;
    end

    assign rise = meas_s & ~meas_d;

    always_ff @(posedge clk) begin
        if (rst) st <= PD_IDLE;
        else     st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            PD_IDLE:   if (rise)  st_nx = PD_CHARGE;
            PD_CHARGE: if (carry) st_nx = PD_IDLE;
            default:   st_nx = PD_IDLE;
        endcase
    end

    always_comb begin
        pos_en = (st == PD_CHARGE);
    end

    assert_rise_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (!pos_en && rise) |=> pos_en);
    assert_carry_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (pos_en && carry) |=> !pos_en);
    assert_rise_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (pos_en && !carry) |=> pos_en);
endmodule

// File: rtl/fdc_neg_pulse.sv
module fdc_neg_pulse
    import fdc_loop_pkg::*;
#(
    parameter int NEG_HALVES = 17
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_half,
    input  logic carry,
    output logic neg_en
);
    localparam int HW = $clog2(NEG_HALVES + 1);

    np_state_e      st, st_nx;
    logic [HW-1:0]  halfcnt, halfcnt_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= NP_IDLE;
            halfcnt <= '0;
        end else begin
            st      <= st_nx;
            halfcnt <= halfcnt_nx;
        end
    end

    always_comb begin
        st_nx      = st;
        halfcnt_nx = halfcnt;
        if (carry) begin
            st_nx      = NP_ACTIVE;
            halfcnt_nx = HW'(NEG_HALVES);
        end else begin
            unique case (st)
                NP_IDLE: ;
                NP_ACTIVE: begin
                    if (tick_half) begin
                        if (halfcnt == HW'(1)) begin
                            st_nx      = NP_IDLE;
                            halfcnt_nx = '0;
                        end else begin
                            halfcnt_nx = halfcnt - HW'(1);
                        end
                    end
                end
                default: st_nx = NP_IDLE;
            endcase
        end
    end

    always_comb begin
        neg_en = (st == NP_ACTIVE);
    end

    assert_pulse_start_R4: assert property (@(posedge clk) disable iff (rst)
        (!neg_en && carry) |=> neg_en);
    assert_pulse_live_R4: assert property (@(posedge clk) disable iff (rst)
        neg_en |-> (halfcnt != '0));
    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (!neg_en && !carry) |=> !neg_en);
    assert_pulse_restart_R5: assert property (@(posedge clk) disable iff (rst)
        (neg_en && carry) |=> (neg_en && halfcnt == HW'(NEG_HALVES)));
endmodule

// File: rtl/fdc_rate_loop.sv
module fdc_rate_loop
    import fdc_loop_pkg::*;
#(
    parameter int CNT_W         = 5,
    parameter int ACC_W         = 6,
    parameter int ACC_MIN       = -16,
    parameter int ACC_MAX       = 12,
    parameter int CENTER_RELOAD = 19
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick_mclk,
    input  logic [2:0]              code_s,
    output logic                    carry,
    output logic signed [ACC_W-1:0] acc,
    output logic                    valid
);
    localparam int CNT_TOP = (1 << CNT_W) - 1;

    logic [CNT_W-1:0]        cnt;
    logic [CNT_W-1:0]        reload;
    logic signed [ACC_W-1:0] acc_nx;

    assign carry = tick_mclk && (cnt == '0);

    always_comb begin
        int sum_a;
        int sum_r;
        sum_a = int'(acc) + int'(level_of(code_s));
        if (sum_a > ACC_MAX) sum_a = ACC_MAX;
        if (sum_a < ACC_MIN) sum_a = ACC_MIN;
        acc_nx = ACC_W'(sum_a);
        sum_r  = sum_a + CENTER_RELOAD;
        if (sum_r > CNT_TOP) sum_r = CNT_TOP;
        if (sum_r < 0)       sum_r = 0;
        reload = CNT_W'(sum_r);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            acc   <= '0;
            valid <= 1'b0;
        end else begin
            valid <= carry;
            if (carry) begin
                acc <= acc_nx;
                cnt <= reload;
            end else if (tick_mclk) begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

    assert_acc_range_R7: assert property (@(posedge clk) disable iff (rst)
        (int'(acc) >= ACC_MIN) && (int'(acc) <= ACC_MAX));
    assert_reload_tracks_word_R8: assert property (@(posedge clk) disable iff (rst)
        carry |=> (int'(cnt) == int'(acc) + CENTER_RELOAD));
    assert_valid_single_R9: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);
    assert_word_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !carry |=> $stable(acc));
endmodule

// File: rtl/fdc_loop_ctrl.sv
module fdc_loop_ctrl
    import fdc_loop_pkg::*;
#(
    parameter int CNT_W         = 5,
    parameter int ACC_W         = 6,
    parameter int ACC_MIN       = -16,
    parameter int ACC_MAX       = 12,
    parameter int CENTER_RELOAD = 19,
    parameter int NEG_HALVES    = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_mclk,
    input  logic             tick_half,
    input  logic             meas_in,
    input  logic [2:0]       adc_code,
    output logic             pos_pump_en,
    output logic             neg_pump_en,
    output logic [ACC_W-1:0] freq_word,
    output logic             freq_valid
);
    logic                    meas_s;
    logic [2:0]              code_s;
    logic                    carry;
    logic signed [ACC_W-1:0] acc;

    fdc_sync #(.WIDTH(1)) u_meas_sync (
        .clk (clk), .rst (rst), .d (meas_in), .q (meas_s)
    );

    fdc_sync #(.WIDTH(3)) u_code_sync (
        .clk (clk), .rst (rst), .d (adc_code), .q (code_s)
    );

    fdc_rate_loop #(
        .CNT_W         (CNT_W),
        .ACC_W         (ACC_W),
        .ACC_MIN       (ACC_MIN),
        .ACC_MAX       (ACC_MAX),
        .CENTER_RELOAD (CENTER_RELOAD)
    ) u_rate (
        .clk       (clk),
        .rst       (rst),
        .tick_mclk (tick_mclk),
        .code_s    (code_s),
        .carry     (carry),
        .acc       (acc),
        .valid     (freq_valid)
    );

    fdc_phase_det u_pd (
        .clk    (clk),
        .rst    (rst),
        .meas_s (meas_s),
        .carry  (carry),
        .pos_en (pos_pump_en)
    );

    fdc_neg_pulse #(.NEG_HALVES(NEG_HALVES)) u_neg (
        .clk       (clk),
        .rst       (rst),
        .tick_half (tick_half),
        .carry     (carry),
        .neg_en    (neg_pump_en)
    );

    assign freq_word = acc;

    assert_carry_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
        carry |-> tick_mclk);
    assert_valid_with_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        freq_valid |-> neg_pump_en);
endmodule

// File: tb/fdc_loop_ctrl_tb_top.sv
module fdc_loop_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MCLK_DIV   = 10;
    localparam int HALF_DIV   = 5;
    localparam int W_MIN      = -16;
    localparam int W_MAX      = 12;
    localparam int BASE_TICKS = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_mclk = 1'b0;
    logic       tick_half = 1'b0;
    logic       meas_in = 1'b0;
    logic [2:0] adc_code = 3'b000;
    logic       pos_pump_en, neg_pump_en, freq_valid;
    logic [5:0] freq_word;

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    int  ph = 0;
    int  prev_w = 0;
    int  prev_t = 0;
    bit  have_prev = 0;
    bit  neg_at_valid = 0;
    bit  done = 0;

    fdc_loop_ctrl dut_i (
        .clk (clk), .rst (rst), .tick_mclk (tick_mclk), .tick_half (tick_half),
        .meas_in (meas_in), .adc_code (adc_code), .pos_pump_en (pos_pump_en),
        .neg_pump_en (neg_pump_en), .freq_word (freq_word), .freq_valid (freq_valid)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        forever begin
            @(negedge clk);
            ph = (ph + 1) % MCLK_DIV;
            tick_mclk = (ph == 0);
            tick_half = (ph % HALF_DIV == 0);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        if (v > W_MAX) return W_MAX;
        if (v < W_MIN) return W_MIN;
        return v;
    endfunction

    task automatic next_valid(input int lvl, input string tag);
        int w;
        int ew;
        do @(negedge clk); while (!freq_valid);
        neg_at_valid = neg_pump_en;
        w  = int'($signed(freq_word));
        ew = sat(prev_w + lvl);
        check(w == ew, {"R7 word ", tag}, w, ew);
        if (have_prev)
            check(cyc - prev_t == (BASE_TICKS + prev_w) * MCLK_DIV,
                  {"R8 interval ", tag}, cyc - prev_t, (BASE_TICKS + prev_w) * MCLK_DIV);
        prev_w = w;
        prev_t = cyc;
        have_prev = 1;
        @(negedge clk);
        check(!freq_valid, {"R9 single pulse ", tag}, int'(freq_valid), 0);
        check(int'($signed(freq_word)) == w, {"R9 word hold ", tag},
              int'($signed(freq_word)), w);
    endtask

    task automatic run_code(input logic [2:0] bits, input int lvl, input int n, input string tag);
        adc_code = bits;
        for (int i = 0; i < n; i++) next_valid(lvl, tag);
    endtask

    task automatic t_reset();
        int t0;
        check(!pos_pump_en && !neg_pump_en && !freq_valid, "R1 outputs low in reset",
              int'({pos_pump_en, neg_pump_en, freq_valid}), 0);
        check(freq_word == 6'd0, "R1 word zero in reset", int'(freq_word), 0);
        @(negedge clk);
        rst = 1'b0;
        t0 = cyc;
        prev_w = 0;
        have_prev = 0;
        next_valid(0, "first carry");
        check(prev_t - t0 <= MCLK_DIV, "R1 first carry on first tick", prev_t - t0, MCLK_DIV);
    endtask

    task automatic t_centre_and_width();
        int n;
        next_valid(0, "R10 centre");
        check(prev_w == 0, "R10 word stays zero", prev_w, 0);
        check(neg_at_valid, "R4 pulse starts with carry", int'(neg_at_valid), 1);
        n = 2;
        forever begin
            @(negedge clk);
            if (neg_pump_en) n++;
            else break;
        end
        check(n == 17 * HALF_DIV, "R4 pulse width", n, 17 * HALF_DIV);
    endtask

    task automatic t_code_map();
        run_code(3'b001, 1, 2, "R6 +1");
        run_code(3'b011, 2, 2, "R6 011 clamps +2");
        run_code(3'b010, 2, 4, "R7 high saturation");
        run_code(3'b101, -2, 2, "R6 101 clamps -2");
        run_code(3'b100, -2, 1, "R6 100 clamps -2");
        run_code(3'b111, -1, 2, "R6 -1");
        run_code(3'b110, -2, 12, "R7 low saturation");
    endtask

    task automatic t_restart();
        int lows = 0;
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (!neg_pump_en) lows++;
        end
        check(lows == 0, "R5 pulse restarts without gap", lows, 0);
        have_prev = 0;
        check(int'($signed(freq_word)) == W_MIN, "R7 held at minimum",
              int'($signed(freq_word)), W_MIN);
    endtask

    task automatic t_phase();
        run_code(3'b000, 0, 1, "R7 hold at zero code");
        check(!pos_pump_en, "R3 flag clear after carry", int'(pos_pump_en), 0);
        meas_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(!pos_pump_en, "R2 not before third edge", int'(pos_pump_en), 0);
        @(negedge clk);
        check(pos_pump_en, "R2 set on third edge", int'(pos_pump_en), 1);
        meas_in = 1'b0;
        repeat (4) @(negedge clk);
        meas_in = 1'b1;
        repeat (5) @(negedge clk);
        check(pos_pump_en, "R3 second rise ignored", int'(pos_pump_en), 1);
        next_valid(0, "R3 clearing carry");
        check(!pos_pump_en, "R3 cleared at carry", int'(pos_pump_en), 0);
        repeat (20) @(negedge clk);
        check(!pos_pump_en, "R3 ignored rise not remembered", int'(pos_pump_en), 0);
        meas_in = 1'b0;
        repeat (2) @(negedge clk);
        meas_in = 1'b1;
        repeat (3) @(negedge clk);
        check(pos_pump_en, "R2 fresh rise sets again", int'(pos_pump_en), 1);
    endtask

    task automatic t_mid_reset();
        rst = 1'b1;
        meas_in = 1'b0;
        repeat (2) @(negedge clk);
        check(!pos_pump_en && !neg_pump_en && !freq_valid, "R1 mid-run reset clears outputs",
              int'({pos_pump_en, neg_pump_en, freq_valid}), 0);
        check(freq_word == 6'd0, "R1 mid-run reset clears word", int'(freq_word), 0);
        rst = 1'b0;
        prev_w = 0;
        have_prev = 0;
        next_valid(0, "R1 restart");
        next_valid(0, "R10 after restart");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_centre_and_width();
        t_code_map();
        t_restart();
        t_phase();
        t_mid_reset();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule